// File: doc/BRIEF.md
# Bus Error Capture and Reporting Unit

This unit gathers error events from the processor side and the PCI side of a host bridge and keeps each one as a sticky status flag. There are five sources: processor address-bus timeout, processor data parity error, PCI parity error, PCI system error and PCI master abort. A flag stays set until software clears it by writing a 1 to its bit in the status register.

Each source has two enables. One sends a machine-check to a bus master. The other raises a shared interrupt request toward the interrupt controller. The machine-check target depends on the source. The processor-side sources and master abort use the master ID latched from the bus logic when such an event arrived. The two PCI pin-driven sources use a default-master field that software writes. The per-master machine-check lines and the interrupt request are level signals. They are computed directly from the stored flags and enables.

Top module: `bridge_err_report`

## Requirements
- R1: After reset, all flags, both enable registers, the latched master ID and the default-master field read 0, every machine-check line is low and the interrupt request is low.
- R2: An event on `err_evt` bit s sets status bit s at the next rising clock edge. The bit positions are: 0 address timeout, 1 data parity, 2 PCI parity, 3 PCI system error, 4 master abort. A set flag stays set while no clear hits it.
- R3: A write to address 0 (status) clears every flag whose write-data bit is 1. Flags whose write-data bit is 0 are left unchanged.
- R4: When an event and a clearing write hit the same flag in the same cycle, the flag ends up set.
- R5: A data parity event (bit 1) is ignored while `dpar_chk_en` is low.
- R6: When an event on source 0, 1 or 4 is accepted, `evt_mid` is latched. It reads back at address 3, bits [MID_W-1:0]. The default-master field is written and read at address 3, bits [8 +: MID_W].
- R7: Machine-check line m is high when source 0, 1 or 4 has its flag set, its machine-check enable set, and the latched master ID equal to m.
- R8: Machine-check line m is high when source 2 or 3 has its flag set, its machine-check enable set, and the default-master field equal to m.
- R9: `irq_o` is the OR over all sources of flag AND interrupt enable. It stays high until every enabled flag is cleared.
- R10: The machine-check enables (address 1) and interrupt enables (address 2) sit in bits [4:0]. They are written by register writes and read back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 status, 1 machine-check enables, 2 interrupt enables, 3 routing |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data for `reg_addr` (combinational) |
| err_evt | input | 5 | One pulse per error source, bit order as in R2 |
| evt_mid | input | MID_W | ID of the master involved in the current event |
| dpar_chk_en | input | 1 | Processor data-bus parity checking enabled |
| mchk_o | output | N_MST | Machine-check line, one per master |
| irq_o | output | 1 | Interrupt request, level |

## Verification
A wrong flag shows up in the status read-back and on the output lines one clock after the event or write that caused it. A wrong latched ID or default-master value moves a machine-check to the other master's line. The bench sweeps every source against every combination of enables, master ID and default master, so a wrong route appears in the same cycle as the flag. A clear or set-priority fault leaves the interrupt at the wrong level at the next sample, and the bench samples that cycle directly.

// File: rtl/berr_pkg.sv
package berr_pkg;
   localparam int NSRC     = 5;
   localparam int SRC_ATMO = 0;
   localparam int SRC_DPAR = 1;
   localparam int SRC_PPAR = 2;
   localparam int SRC_PSYS = 3;
   localparam int SRC_MABT = 4;
   // sources whose machine-check follows the latched master id
   localparam logic [NSRC-1:0] ROUTE_BY_ID = 5'b10011;
   localparam int DFLT_LSB = 8;

   typedef enum logic [1:0] {
      RA_STATUS  = 2'd0,
      RA_MCHK_EN = 2'd1,
      RA_IRQ_EN  = 2'd2,
      RA_ROUTE   = 2'd3
   } reg_addr_e;
endpackage

// File: rtl/berr_flags.sv
module berr_flags #(
   parameter int NSRC = 5
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] set_i,
   input  logic [NSRC-1:0] clr_i,
   output logic [NSRC-1:0] flags_o
);
   initial begin
      assert (NSRC >= 1) else $error("berr_flags: NSRC must be at least 1");
   end

   for (genvar i = 0; i < NSRC; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        flags_o[i] <= 1'b0;
         else if (set_i[i]) flags_o[i] <= 1'b1;
         else if (clr_i[i]) flags_o[i] <= 1'b0;
      end

      // R4
      set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
         set_i[i] |=> flags_o[i]);
      // R3
      w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (clr_i[i] && !set_i[i]) |=> !flags_o[i]);
      // R2
      sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (flags_o[i] && !clr_i[i]) |=> flags_o[i]);
   end
endmodule

// File: rtl/berr_regs.sv
module berr_regs
   import berr_pkg::*;
#(
   parameter int DW    = 16,
   parameter int NSRC  = 5,
   parameter int MID_W = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we_i,
   input  logic [1:0]       addr_i,
   input  logic [DW-1:0]    wdata_i,
   input  logic [NSRC-1:0]  flags_i,
   input  logic             id_hit_i,
   input  logic [MID_W-1:0] evt_mid_i,
   output logic [DW-1:0]    rdata_o,
   output logic [NSRC-1:0]  clr_o,
   output logic [NSRC-1:0]  mchk_en_o,
   output logic [NSRC-1:0]  irq_en_o,
   output logic [MID_W-1:0] cap_mid_o,
   output logic [MID_W-1:0] dflt_o
);
   localparam int TOP_USED = DFLT_LSB + MID_W;

   initial begin
      assert (DW >= TOP_USED) else $error("berr_regs: DW too narrow for routing field");
      assert (NSRC <= DFLT_LSB) else $error("berr_regs: NSRC overlaps routing field");
   end

   logic wr_status, wr_mchk, wr_irq, wr_route;
   logic unused_wdata;

   assign wr_status    = we_i && (addr_i == RA_STATUS);
   assign wr_mchk      = we_i && (addr_i == RA_MCHK_EN);
   assign wr_irq       = we_i && (addr_i == RA_IRQ_EN);
   assign wr_route     = we_i && (addr_i == RA_ROUTE);
   assign clr_o        = wr_status ? wdata_i[NSRC-1:0] : '0;
   assign unused_wdata = ^wdata_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mchk_en_o <= '0;
         irq_en_o  <= '0;
         cap_mid_o <= '0;
         dflt_o    <= '0;
      end else begin
         if (wr_mchk)  mchk_en_o <= wdata_i[NSRC-1:0];
         if (wr_irq)   irq_en_o  <= wdata_i[NSRC-1:0];
         if (wr_route) dflt_o    <= wdata_i[DFLT_LSB +: MID_W];
         if (id_hit_i) cap_mid_o <= evt_mid_i;
      end
   end

   always_comb begin
      rdata_o = '0;
      case (reg_addr_e'(addr_i))
         RA_STATUS:  rdata_o[NSRC-1:0] = flags_i;
         RA_MCHK_EN: rdata_o[NSRC-1:0] = mchk_en_o;
         RA_IRQ_EN:  rdata_o[NSRC-1:0] = irq_en_o;
         RA_ROUTE: begin
            rdata_o[MID_W-1:0]          = cap_mid_o;
            rdata_o[DFLT_LSB +: MID_W]  = dflt_o;
         end
         default:    rdata_o = '0;
      endcase
   end

   // R6
   mid_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      id_hit_i |=> (cap_mid_o == $past(evt_mid_i)));
   // R6
   mid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !id_hit_i |=> $stable(cap_mid_o));
   // R10
   mchk_en_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_mchk |=> (mchk_en_o == $past(wdata_i[NSRC-1:0])));
   // R10
   irq_en_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_irq |=> (irq_en_o == $past(wdata_i[NSRC-1:0])));
endmodule

// File: rtl/berr_route.sv
module berr_route #(
   parameter int              NSRC   = 5,
   parameter int              N_MST  = 2,
   parameter int              MID_W  = 1,
   parameter logic [NSRC-1:0] BY_ID  = '0
) (
   input  logic [NSRC-1:0]  flags_i,
   input  logic [NSRC-1:0]  mchk_en_i,
   input  logic [NSRC-1:0]  irq_en_i,
   input  logic [MID_W-1:0] cap_mid_i,
   input  logic [MID_W-1:0] dflt_i,
   output logic [N_MST-1:0] mchk_o,
   output logic             irq_o
);
   initial begin
      assert (N_MST >= 2) else $error("berr_route: need at least two masters");
      assert ((1 << MID_W) >= N_MST) else $error("berr_route: MID_W too narrow");
   end

   logic [NSRC-1:0] armed;
   assign armed = flags_i & mchk_en_i;
   assign irq_o = |(flags_i & irq_en_i);

   for (genvar m = 0; m < N_MST; m++) begin : g_mst
      logic hit;
      always_comb begin
         hit = 1'b0;
         for (int s = 0; s < NSRC; s++) begin
            if (armed[s] && ((BY_ID[s] ? cap_mid_i : dflt_i) == MID_W'(m)))
               hit = 1'b1;
         end
      end
      assign mchk_o[m] = hit;
   end
endmodule

// File: rtl/bridge_err_report.sv
module bridge_err_report
   import berr_pkg::*;
#(
   parameter int DW    = 16,
   parameter int N_MST = 2,
   parameter int MID_W = (N_MST > 1) ? $clog2(N_MST) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_we,
   input  logic [1:0]       reg_addr,
   input  logic [DW-1:0]    reg_wdata,
   output logic [DW-1:0]    reg_rdata,
   input  logic [NSRC-1:0]  err_evt,
   input  logic [MID_W-1:0] evt_mid,
   input  logic             dpar_chk_en,
   output logic [N_MST-1:0] mchk_o,
   output logic             irq_o
);
   logic [NSRC-1:0]  evt_ok, clr, flags, mchk_en, irq_en;
   logic [MID_W-1:0] cap_mid, dflt;
   logic             id_hit;

   always_comb begin
      evt_ok = err_evt;
      if (!dpar_chk_en) evt_ok[SRC_DPAR] = 1'b0;
   end
   assign id_hit = |(evt_ok & ROUTE_BY_ID);

   berr_flags #(.NSRC(NSRC)) u_flags (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_i   (evt_ok),
      .clr_i   (clr),
      .flags_o (flags)
   );

   berr_regs #(.DW(DW), .NSRC(NSRC), .MID_W(MID_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .we_i      (reg_we),
      .addr_i    (reg_addr),
      .wdata_i   (reg_wdata),
      .flags_i   (flags),
      .id_hit_i  (id_hit),
      .evt_mid_i (evt_mid),
      .rdata_o   (reg_rdata),
      .clr_o     (clr),
      .mchk_en_o (mchk_en),
      .irq_en_o  (irq_en),
      .cap_mid_o (cap_mid),
      .dflt_o    (dflt)
   );

   berr_route #(.NSRC(NSRC), .N_MST(N_MST), .MID_W(MID_W), .BY_ID(ROUTE_BY_ID)) u_route (
      .flags_i   (flags),
      .mchk_en_i (mchk_en),
      .irq_en_i  (irq_en),
      .cap_mid_i (cap_mid),
      .dflt_i    (dflt),
      .mchk_o    (mchk_o),
      .irq_o     (irq_o)
   );

   // R5
   dpar_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flags[SRC_DPAR]) |-> $past(dpar_chk_en && err_evt[SRC_DPAR]));
   // R9
   irq_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flags == '0) |-> !irq_o);
   // R7
   mchk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((flags & mchk_en) == '0) |-> (mchk_o == '0));
   // R1
   rst_quiet_chk: assert property (@(posedge clk)
      !rst_n |-> (mchk_o == '0 && !irq_o));
endmodule

// File: tb/bridge_err_report_tb.sv
`timescale 1ns/1ps
module bridge_err_report_tb;
   localparam int DW = 16;
   localparam int NM = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          reg_we = 1'b0;
   logic [1:0]    reg_addr = '0;
   logic [DW-1:0] reg_wdata = '0;
   logic [DW-1:0] reg_rdata;
   logic [4:0]    err_evt = '0;
   logic [0:0]    evt_mid = '0;
   logic          dpar_chk_en = 1'b1;
   logic [NM-1:0] mchk_o;
   logic          irq_o;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;

   always #10 clk = ~clk;

   bridge_err_report #(.DW(DW), .N_MST(NM)) u_dut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .err_evt(err_evt),
      .evt_mid(evt_mid), .dpar_chk_en(dpar_chk_en), .mchk_o(mchk_o), .irq_o(irq_o)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0; reg_wdata = '0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [DW-1:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic pulse(input logic [4:0] v, input logic mid);
      @(negedge clk);
      err_evt = v; evt_mid = mid;
      @(negedge clk);
      err_evt = '0;
   endtask

   task automatic summary();
      if (!done) begin
         done = 1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finish");
      summary();
   end

   initial begin
      logic [DW-1:0] d;
      logic          exp_mid;
      logic [NM-1:0] exp_mc;
      int            tgt;
      exp_mid = 1'b0;

      repeat (3) @(negedge clk);
      // R1 reset state
      for (int a = 0; a < 4; a++) begin
         rd(a[1:0], d);
         chk("R1 reg reset", d, 0);
      end
      chk("R1 mchk reset", mchk_o, 0);
      chk("R1 irq reset", irq_o, 0);
      rst_n = 1'b1;

      // R10 enable read-back
      wr(2'd1, 16'h0015); rd(2'd1, d); chk("R10 mchk_en", d, 32'h15);
      wr(2'd2, 16'h000A); rd(2'd2, d); chk("R10 irq_en", d, 32'h0A);

      // sweep: source x enables x master id x default master (R2 R6 R7 R8 R9 R3)
      for (int s = 0; s < 5; s++) begin
         for (int e = 0; e < 4; e++) begin
            for (int mid = 0; mid < 2; mid++) begin
               for (int df = 0; df < 2; df++) begin
                  wr(2'd1, e[0] ? 16'h001F : 16'h0);
                  wr(2'd2, e[1] ? 16'h001F : 16'h0);
                  wr(2'd3, 16'(df) << 8);
                  pulse(5'(1 << s), mid[0]);
                  if (s == 0 || s == 1 || s == 4) exp_mid = mid[0];
                  tgt = (s == 2 || s == 3) ? df : int'(exp_mid);
                  exp_mc = e[0] ? NM'(1 << tgt) : '0;
                  rd(2'd0, d);
                  chk("R2 flag set", d, 32'(1 << s));
                  if (s == 2 || s == 3) chk("R8 default route", mchk_o, exp_mc);
                  else                  chk("R7 id route", mchk_o, exp_mc);
                  chk("R9 irq level", irq_o, e[1]);
                  rd(2'd3, d);
                  chk("R6 route reg", d, 32'(exp_mid) | (32'(df) << 8));
                  wr(2'd0, 16'h001F);
                  rd(2'd0, d);
                  chk("R3 clear all", d, 0);
                  chk("R3 mchk drop", mchk_o, 0);
                  chk("R9 irq drop", irq_o, 0);
               end
            end
         end
      end

      // R5 data parity ignored when checking off
      dpar_chk_en = 1'b0;
      pulse(5'b00010, 1'b1);
      rd(2'd0, d); chk("R5 dpar gated", d, 0);
      rd(2'd3, d); chk("R5 mid untouched", d[0], exp_mid);
      dpar_chk_en = 1'b1;

      // R3 write of zero leaves flags
      pulse(5'b01001, 1'b0);
      wr(2'd0, 16'h0000);
      rd(2'd0, d); chk("R3 write zero", d, 32'h09);
      // R3 partial clear
      wr(2'd0, 16'h0001);
      rd(2'd0, d); chk("R3 partial clear", d, 32'h08);

      // R4 set beats clear in the same cycle
      @(negedge clk);
      err_evt = 5'b00001; reg_we = 1'b1; reg_addr = 2'd0; reg_wdata = 16'h001F;
      @(negedge clk);
      err_evt = '0; reg_we = 1'b0; reg_wdata = '0;
      rd(2'd0, d); chk("R4 set wins", d, 32'h01);
      wr(2'd0, 16'h001F);

      // R9 level held until every enabled flag clears
      wr(2'd2, 16'h001F);
      pulse(5'b01001, 1'b0);
      wr(2'd0, 16'h0001);
      #1 chk("R9 irq held", irq_o, 1);
      wr(2'd0, 16'h0008);
      #1 chk("R9 irq released", irq_o, 0);
      wr(2'd2, 16'h0008);
      pulse(5'b01001, 1'b0);
      wr(2'd0, 16'h0008);
      #1 chk("R9 unenabled flag ignored", irq_o, 0);
      rd(2'd0, d); chk("R2 other flag kept", d, 32'h01);

      // R7 and R8 on both lines at once
      wr(2'd0, 16'h001F);
      wr(2'd1, 16'h001F);
      wr(2'd3, 16'h0100);
      pulse(5'b10100, 1'b0);
      #1 chk("R7 R8 both masters", mchk_o, 2'b11);

      summary();
   end
endmodule